// File: doc/BRIEF.md
# Vector Programmed-I/O Request Launcher

This block sends one remote programmed-I/O request packet at a time, set up through three 64-bit registers. Software first loads a route word and a payload word. It then writes a parameters word holding the request kind, the target address and two identifiers. That last write starts the send.

The bus acknowledge for every register access returns one cycle after the request, without waiting for the packet. The packet leaves as three 64-bit flits on a valid/ready stream, in this order:

1. a header built from the parameter fields,
2. the route word,
3. the payload word.

A busy flag in bit 63 of the parameters register shows a send in progress. While that flag is set, writes that could change the request are dropped.

Software polls busy until it reads clear, then loads route and payload, then writes the parameters word. The payload word is sent for read requests and for write requests alike.

Top module: `vpio_launcher`

## Requirements
- R1: Register offsets on `reg_addr`: 0 holds the route word, 1 holds the payload word, 2 is the parameters word. Offset 3 reads as zero and ignores writes. A read returns the stored value.
- R2: Every request (`reg_req` high for one cycle) is acknowledged by `reg_ack` high in the next cycle, and only then. Read data is presented on `reg_rdata` in the same cycle as the acknowledge.
- R3: A parameters write while idle stores four fields: kind at bit 0 (0 = read, 1 = write), target address at bits 23:3, write ID at bits 39:32 and request ID at bits 50:40. From the next cycle, busy reads as 1 in bit 63 and `pkt_valid` is high.
- R4: The packet is exactly three flits: header, then route word, then payload word. The header carries the stored fields at the R3 positions, with all other bits 0. `pkt_last` is high only with the third flit.
- R5: While `pkt_valid` is high and `pkt_ready` is low, `pkt_flit` and `pkt_last` hold their values.
- R6: A flit is taken on each cycle with `pkt_valid` and `pkt_ready` both high. After the third flit is taken, busy and `pkt_valid` are low from the next cycle.
- R7: A parameters write while busy is acknowledged but ignored. Stored fields and flits in flight do not change, and no second packet follows.
- R8: Route and payload writes while busy are acknowledged but ignored. Readback and the packet keep the earlier values.
- R9: Reserved parameter bits (2:1, 31:24, 62:51) read as 0. Bit 63 reports busy only; a written value there is discarded.
- R10: The payload word is sent as the third flit for both request kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 64 | Write data |
| reg_ack | output | 1 | Access acknowledge, one cycle after the request |
| reg_rdata | output | 64 | Read data, valid with the acknowledge |
| pkt_valid | output | 1 | Outgoing flit valid |
| pkt_ready | input | 1 | Downstream accepts the flit |
| pkt_flit | output | 64 | Outgoing flit |
| pkt_last | output | 1 | Marks the final flit of a packet |

## Verification
The assertions assume that `reg_req`, `reg_we` and `reg_addr` are driven to known values in every cycle after reset. They also assume that `pkt_ready` does not depend on the current flit. The acknowledge properties count each request-high cycle as its own access, so the stimulus raises `reg_req` for exactly one cycle per access. The bench changes inputs only on the falling clock edge, and holds `pkt_ready` low during register accesses made while a packet is pending, so each step of a send is observed on its own.

// File: rtl/vpio_pkg.sv
package vpio_pkg;
  localparam int FLIT_W     = 64;
  localparam int REG_ADDR_W = 2;
  localparam int NUM_FLITS  = 3;
  localparam int IDX_W      = $clog2(NUM_FLITS);

  localparam int KIND_BIT = 0;
  localparam int TGT_LO   = 3;
  localparam int TGT_HI   = 23;
  localparam int WID_LO   = 32;
  localparam int WID_HI   = 39;
  localparam int RID_LO   = 40;
  localparam int RID_HI   = 50;
  localparam int BUSY_BIT = 63;

  typedef enum logic [REG_ADDR_W-1:0] {
    OFF_ROUTE  = 2'd0,
    OFF_DATA   = 2'd1,
    OFF_PARAMS = 2'd2,
    OFF_SPARE  = 2'd3
  } reg_off_e;

  typedef struct packed {
    logic [RID_HI-RID_LO:0] req_id;
    logic [WID_HI-WID_LO:0] write_id;
    logic [TGT_HI-TGT_LO:0] target;
    logic                   is_write;
  } launch_fields_t;

  function automatic launch_fields_t unpack_fields(input logic [FLIT_W-1:0] w);
    launch_fields_t f;
    f.is_write = w[KIND_BIT];
    f.target   = w[TGT_HI:TGT_LO];
    f.write_id = w[WID_HI:WID_LO];
    f.req_id   = w[RID_HI:RID_LO];
    return f;
  endfunction

  function automatic logic [FLIT_W-1:0] pack_fields(input launch_fields_t f,
                                                    input logic busy);
    logic [FLIT_W-1:0] w;
    w                = '0;
    w[KIND_BIT]      = f.is_write;
    w[TGT_HI:TGT_LO] = f.target;
    w[WID_HI:WID_LO] = f.write_id;
    w[RID_HI:RID_LO] = f.req_id;
    w[BUSY_BIT]      = busy;
    return w;
  endfunction
endpackage

// File: rtl/vpio_regfile.sv
module vpio_regfile
  import vpio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  we,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [FLIT_W-1:0]     wdata,
  input  logic                  busy,
  output logic                  ack,
  output logic [FLIT_W-1:0]     rdata,
  output logic                  launch,
  output logic [FLIT_W-1:0]     route_q,
  output logic [FLIT_W-1:0]     data_q,
  output launch_fields_t        fields_q
);
  reg_off_e          off;
  logic              wr_ok, rd_hit;
  logic              route_en, data_en;
  logic [FLIT_W-1:0] route_d, data_d, rdata_d, view;
  launch_fields_t    fields_d;
  logic              ack_d;

  assign off    = reg_off_e'(addr);
  assign wr_ok  = req && we && !busy;
  assign rd_hit = req && !we;

  assign launch   = wr_ok && (off == OFF_PARAMS);
  assign route_en = wr_ok && (off == OFF_ROUTE);
  assign data_en  = wr_ok && (off == OFF_DATA);

  always_comb begin
    unique case (off)
      OFF_ROUTE:  view = route_q;
      OFF_DATA:   view = data_q;
      OFF_PARAMS: view = pack_fields(fields_q, busy);
      default:    view = '0;
    endcase
  end

  always_comb begin
    route_d  = route_en ? wdata : route_q;
    data_d   = data_en  ? wdata : data_q;
    fields_d = launch   ? unpack_fields(wdata) : fields_q;
    rdata_d  = rd_hit   ? view  : rdata;
    ack_d    = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q  <= '0;
      data_q   <= '0;
      fields_q <= '0;
      rdata    <= '0;
      ack      <= 1'b0;
    end else begin
      route_q  <= route_d;
      data_q   <= data_d;
      fields_q <= fields_d;
      rdata    <= rdata_d;
      ack      <= ack_d;
    end
  end
endmodule

// File: rtl/vpio_sequencer.sv
module vpio_sequencer
  import vpio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             out_ready,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             at_last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FLITS - 1);

  logic             busy_d;
  logic [IDX_W-1:0] idx_d;
  logic             take;

  assign at_last = (idx == LAST_IDX);
  assign take    = busy && out_ready;

  always_comb begin
    busy_d = busy;
    idx_d  = idx;
    if (launch) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (take) begin
      if (at_last) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else begin
      busy <= busy_d;
      idx  <= idx_d;
    end
  end
endmodule

// File: rtl/vpio_flit_mux.sv
module vpio_flit_mux
  import vpio_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  launch_fields_t    fields,
  input  logic [FLIT_W-1:0] route,
  input  logic [FLIT_W-1:0] data,
  output logic [FLIT_W-1:0] flit
);
  logic [FLIT_W-1:0] slot [NUM_FLITS];

  assign slot[0] = pack_fields(fields, 1'b0);
  assign slot[1] = route;
  assign slot[2] = data;

  always_comb begin
    flit = '0;
    for (int i = 0; i < NUM_FLITS; i++) begin
      if (idx == IDX_W'(i)) flit = slot[i];
    end
  end
endmodule

// File: rtl/vpio_launcher.sv
module vpio_launcher
  import vpio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_req,
  input  logic                  reg_we,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [FLIT_W-1:0]     reg_wdata,
  output logic                  reg_ack,
  output logic [FLIT_W-1:0]     reg_rdata,
  output logic                  pkt_valid,
  input  logic                  pkt_ready,
  output logic [FLIT_W-1:0]     pkt_flit,
  output logic                  pkt_last
);
  logic              busy, launch, at_last;
  logic [IDX_W-1:0]  idx;
  logic [FLIT_W-1:0] route_q, data_q;
  launch_fields_t    fields_q;

  vpio_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (reg_req),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .busy     (busy),
    .ack      (reg_ack),
    .rdata    (reg_rdata),
    .launch   (launch),
    .route_q  (route_q),
    .data_q   (data_q),
    .fields_q (fields_q)
  );

  vpio_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .out_ready (pkt_ready),
    .busy      (busy),
    .idx       (idx),
    .at_last   (at_last)
  );

  vpio_flit_mux u_mux (
    .idx    (idx),
    .fields (fields_q),
    .route  (route_q),
    .data   (data_q),
    .flit   (pkt_flit)
  );

  assign pkt_valid = busy;
  assign pkt_last  = busy && at_last;
endmodule

// File: rtl/vpio_launcher_chk.sv
module vpio_launcher_chk
  import vpio_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_req,
  input logic                  reg_we,
  input logic [REG_ADDR_W-1:0] reg_addr,
  input logic                  reg_ack,
  input logic [FLIT_W-1:0]     reg_rdata,
  input logic                  pkt_valid,
  input logic                  pkt_ready,
  input logic [FLIT_W-1:0]     pkt_flit,
  input logic                  pkt_last,
  input logic                  busy
);
  localparam logic [FLIT_W-1:0] RSV_MASK = 64'h7FF8_0000_FF00_0006;

  logic prev_rd_params;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_rd_params <= 1'b0;
    else        prev_rd_params <= reg_req && !reg_we && (reg_addr == OFF_PARAMS);
  end

  assert_ack_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> reg_ack);
  assert_ack_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_req |=> !reg_ack);
  assert_launch_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_addr == OFF_PARAMS && !busy) |=> (busy && pkt_valid));
  assert_last_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_last |-> pkt_valid);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_flit) && $stable(pkt_last)));
  assert_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready && pkt_last) |=> !pkt_valid);
  assert_busy_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_req && reg_we && reg_addr == OFF_PARAMS && !pkt_ready) |=>
      (busy && $stable(pkt_flit)));
  assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_ack && prev_rd_params) |-> ((reg_rdata & RSV_MASK) == '0));
endmodule

bind vpio_launcher vpio_launcher_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_req   (reg_req),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_ack   (reg_ack),
  .reg_rdata (reg_rdata),
  .pkt_valid (pkt_valid),
  .pkt_ready (pkt_ready),
  .pkt_flit  (pkt_flit),
  .pkt_last  (pkt_last),
  .busy      (busy)
);

// File: tb/vpio_launcher_bench.sv
`timescale 1ns/1ps
module vpio_launcher_bench;
  localparam logic [63:0] FIELD_MASK = 64'h0007_FFFF_00FF_FFF9;
  localparam logic [63:0] BUSY_MASK  = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_req, reg_we, pkt_ready;
  logic [1:0]  reg_addr;
  logic [63:0] reg_wdata;
  logic        reg_ack, pkt_valid, pkt_last;
  logic [63:0] reg_rdata, pkt_flit;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  vpio_launcher u_vpio_launcher (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
    .reg_rdata(reg_rdata), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_flit(pkt_flit), .pkt_last(pkt_last)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_op(input logic we, input logic [1:0] a, input logic [63:0] d,
                        output logic [63:0] rd);
    reg_req = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    check("R2 ack", {63'd0, reg_ack}, 64'd1);
    rd = reg_rdata;
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  // Collects three flits; stall_mask bit i holds ready low one cycle before flit i.
  task automatic collect(input string tag, input logic [63:0] e0, input logic [63:0] e1,
                         input logic [63:0] e2, input logic [2:0] stall_mask);
    logic [63:0] exp_f [3];
    logic [63:0] seen;
    exp_f[0] = e0; exp_f[1] = e1; exp_f[2] = e2;
    for (int i = 0; i < 3; i++) begin
      check({tag, " R6 valid"}, {63'd0, pkt_valid}, 64'd1);
      seen = pkt_flit;
      if (stall_mask[i]) begin
        pkt_ready = 1'b0;
        @(posedge clk); @(negedge clk);
        check({tag, " R5 hold"}, pkt_flit, seen);
      end
      check({tag, " R4 flit"}, pkt_flit, exp_f[i]);
      check({tag, " R4 last"}, {63'd0, pkt_last}, {63'd0, (i == 2)});
      pkt_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      pkt_ready = 1'b0;
    end
    check({tag, " R6 idle"}, {63'd0, pkt_valid}, 64'd0);
  endtask

  task automatic t_reset;
    check("R2 reset ack", {63'd0, reg_ack}, 64'd0);
    check("R6 reset valid", {63'd0, pkt_valid}, 64'd0);
    check("R4 reset last", {63'd0, pkt_last}, 64'd0);
  endtask

  task automatic t_regs_R1;
    logic [63:0] rd;
    reg_op(1'b1, 2'd0, 64'h1111_2222_3333_4444, rd);
    reg_op(1'b1, 2'd1, 64'hAAAA_BBBB_CCCC_DDDD, rd);
    reg_op(1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, rd);
    reg_op(1'b0, 2'd0, 64'd0, rd); check("R1 route rb", rd, 64'h1111_2222_3333_4444);
    reg_op(1'b0, 2'd1, 64'd0, rd); check("R1 data rb", rd, 64'hAAAA_BBBB_CCCC_DDDD);
    reg_op(1'b0, 2'd3, 64'd0, rd); check("R1 spare rb", rd, 64'd0);
  endtask

  task automatic t_launch_write_R3;
    logic [63:0] rd, p;
    p = 64'hFFFF_A5A5_C3C3_C3C7;
    reg_op(1'b1, 2'd2, p, rd);
    check("R3 valid after launch", {63'd0, pkt_valid}, 64'd1);
    reg_op(1'b0, 2'd2, 64'd0, rd);
    check("R3 R9 params busy rb", rd, (p & FIELD_MASK) | BUSY_MASK);
    collect("wr", p & FIELD_MASK, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD, 3'b000);
    reg_op(1'b0, 2'd2, 64'd0, rd);
    check("R9 busy clear rb", rd, p & FIELD_MASK);
  endtask

  task automatic t_read_stall_R10;
    logic [63:0] rd, p;
    p = 64'h0001_2345_00AB_CDE8;
    reg_op(1'b1, 2'd1, 64'h0BAD_F00D_1234_5678, rd);
    reg_op(1'b1, 2'd2, p, rd);
    collect("rd R10", p & FIELD_MASK, 64'h1111_2222_3333_4444,
            64'h0BAD_F00D_1234_5678, 3'b111);
  endtask

  task automatic t_busy_ignore_R7;
    logic [63:0] rd, p1, p2;
    p1 = 64'h0004_5601_0012_3459;
    p2 = 64'h0003_2100_00FE_DCB8;
    reg_op(1'b1, 2'd0, 64'h5555_6666_7777_8888, rd);
    reg_op(1'b1, 2'd1, 64'h9999_0000_1111_2222, rd);
    reg_op(1'b1, 2'd2, p1, rd);
    reg_op(1'b1, 2'd2, p2, rd);
    reg_op(1'b1, 2'd0, 64'hDEAD_DEAD_DEAD_DEAD, rd);
    reg_op(1'b1, 2'd1, 64'hBEEF_BEEF_BEEF_BEEF, rd);
    reg_op(1'b0, 2'd0, 64'd0, rd); check("R8 route kept", rd, 64'h5555_6666_7777_8888);
    reg_op(1'b0, 2'd1, 64'd0, rd); check("R8 data kept", rd, 64'h9999_0000_1111_2222);
    reg_op(1'b0, 2'd2, 64'd0, rd); check("R7 params kept", rd, (p1 & FIELD_MASK) | BUSY_MASK);
    collect("busy R7 R8", p1 & FIELD_MASK, 64'h5555_6666_7777_8888,
            64'h9999_0000_1111_2222, 3'b010);
    pkt_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      check("R7 no second packet", {63'd0, pkt_valid}, 64'd0);
    end
    pkt_ready = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_req = 1'b0; reg_we = 1'b0; reg_addr = 2'd0;
    reg_wdata = '0; pkt_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs_R1();
    t_launch_write_R3();
    t_read_stall_R10();
    t_busy_ignore_R7();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule